// File: doc/BRIEF.md
# Dual-Address DMA Transfer Channel

This block is one DMA channel that copies data between two memory locations, one byte or one 16-bit word per transfer request. Software supplies a start source address, a start destination address, an update mode for each of those addresses, the data size, a transfer count and an interrupt enable. It writes them all in one cycle with a load strobe, which also arms the channel. Each accepted request produces a read on the shared memory bus from the current source address. The channel latches the returned data and then writes it to the current destination address. After the write, both addresses move by the data size in their chosen direction, and the count drops by one.

When the count runs out, the channel disarms itself. If the interrupt was enabled, it raises an interrupt request, which stays high until software clears it or loads a new job.

The controller has three states. In `ST_IDLE` no bus access is made and requests are sampled. `ST_READ` holds a source read until the bus signals ready. `ST_WRITE` holds a destination write until ready. The transitions are: `ST_IDLE` to `ST_READ` on an armed request; `ST_READ` to `ST_WRITE` on read ready; `ST_WRITE` to `ST_IDLE` on write ready. In every other case the state is held.

Top module: `dma_xfer_channel`

## Requirements
- R1: A synchronous reset clears the enable (`chan_en`), the interrupt (`irq`) and any bus access (`bus_req` low), even when it arrives in the middle of a transfer.
- R2: A `cfg_load` pulse accepted in `ST_IDLE` sets `chan_en` high and `irq` low from the next cycle. It also loads the addresses, modes, size, count and interrupt enable.
- R3: Each accepted request makes exactly one read access (`bus_we`=0) followed by one write access (`bus_we`=1). In word mode (`cfg_word`=1) the write data equals the 16-bit read data. In byte mode the write data is `{8'h00, rdata[7:0]}`.
- R4: After each write, each address is updated by its own 2-bit mode: 0 or 3 holds, 1 adds the step, 2 subtracts the step. The step is 1 for bytes and 2 for words, and the arithmetic wraps modulo 2^24.
- R5: In word mode, bit 0 of `bus_addr` is driven as 0 on every access.
- R6: The counter decrements once per completed transfer. When it reaches zero, `chan_en` drops after exactly the loaded number of transfers.
- R7: A loaded count of zero yields 2^CNT_W transfers, which is 65,536 at the default width of 16.
- R8: On completion `irq` rises if and only if the loaded interrupt enable was 1. It then stays high until an `irq_clr` pulse or an accepted `cfg_load`.
- R9: A request that arrives while the channel is disabled, or while a transfer is in progress, causes no bus access.
- R10: While `bus_req` is high and `bus_rdy` is low, the access (address, direction and request) holds stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_load | input | 1 | Load job settings and arm the channel |
| cfg_src | input | 24 | Start source address |
| cfg_dst | input | 24 | Start destination address |
| cfg_count | input | CNT_W | Transfer count, 0 meaning 2^CNT_W |
| cfg_src_mode | input | 2 | Source address update mode |
| cfg_dst_mode | input | 2 | Destination address update mode |
| cfg_word | input | 1 | 1 = word transfers, 0 = byte transfers |
| cfg_irq_en | input | 1 | Raise irq on completion |
| irq_clr | input | 1 | Clear the interrupt request |
| xfer_req | input | 1 | Transfer request |
| bus_req | output | 1 | Bus access active |
| bus_we | output | 1 | 1 = write access, 0 = read access |
| bus_addr | output | 24 | Access address |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data |
| bus_rdy | input | 1 | Access completes on this cycle |
| chan_en | output | 1 | Channel armed |
| irq | output | 1 | Completion interrupt request |

## Verification
Two situations are hard to reach from the ports. The first is a request that lands while a transfer is still waiting on the bus. The bench produces it by adding wait states, which keeps `ST_READ` occupied, and pulsing `xfer_req` in that window. It then counts the bus accesses that follow. The second is the zero-count case, which at full width takes far too long to reach. The bench therefore builds the channel with an 8-bit counter, so a zero load must give exactly 256 transfers. Around those two cases, it sweeps every pairing of source mode, destination mode and data size, with odd starting addresses that wrap.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } chan_state_t;

    localparam logic [1:0] AM_HOLD = 2'd0;
    localparam logic [1:0] AM_INC  = 2'd1;
    localparam logic [1:0] AM_DEC  = 2'd2;

endpackage

// File: rtl/dma_addr_unit.sv
module dma_addr_unit #(
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic [1:0]    mode,
    input  logic          word,
    input  logic          step,
    output logic [AW-1:0] cur
);
    import dma_chan_pkg::*;

    localparam logic [AW-1:0] STEP_B = AW'(1);
    localparam logic [AW-1:0] STEP_W = AW'(2);

    logic [AW-1:0] stride;

    always_comb begin
        stride = word ? STEP_W : STEP_B;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else if (load) begin
            cur <= load_val;
        end else if (step) begin
            unique case (mode)
                AM_INC:  cur <= cur + stride;
                AM_DEC:  cur <= cur - stride;
                default: cur <= cur;
            endcase
        end
    end

    // R4
    hold_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !load && (mode == 2'd0 || mode == 2'd3)) |=> $stable(cur));

endmodule

// File: rtl/dma_xfer_counter.sv
module dma_xfer_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic          last
);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (dec) begin
            remain <= remain - ONE;
        end
    end

    always_comb begin
        last = (remain == ONE);
    end

    // R6
    count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !dec) |=> $stable(remain));

endmodule

// File: rtl/dma_chan_fsm.sv
module dma_chan_fsm
    import dma_chan_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cfg_load,
    input  logic cfg_irq_en,
    input  logic irq_clr,
    input  logic xfer_req,
    input  logic bus_rdy,
    input  logic last,
    output logic load_ok,
    output logic bus_req,
    output logic bus_we,
    output logic rd_latch,
    output logic wr_done,
    output logic chan_en,
    output logic irq
);
    chan_state_t state, state_nx;
    logic        irq_en_q;
    logic        start;

    always_comb begin
        load_ok  = cfg_load && (state == ST_IDLE);
        start    = chan_en && xfer_req && !cfg_load;
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start)   state_nx = ST_READ;
            ST_READ:  if (bus_rdy) state_nx = ST_WRITE;
            ST_WRITE: if (bus_rdy) state_nx = ST_IDLE;
            default:               state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    always_comb begin
        bus_req  = (state == ST_READ) || (state == ST_WRITE);
        bus_we   = (state == ST_WRITE);
        rd_latch = (state == ST_READ) && bus_rdy;
        wr_done  = (state == ST_WRITE) && bus_rdy;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            chan_en  <= 1'b0;
            irq      <= 1'b0;
            irq_en_q <= 1'b0;
        end else if (load_ok) begin
            chan_en  <= 1'b1;
            irq      <= 1'b0;
            irq_en_q <= cfg_irq_en;
        end else if (wr_done && last) begin
            chan_en <= 1'b0;
            if (irq_en_q) irq <= 1'b1;
        end else if (irq_clr) begin
            irq <= 1'b0;
        end
    end

    // R6
    en_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_done && last) |=> !chan_en);

    // R9
    req_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> chan_en);

    // R9
    idle_stays_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !start) |=> !bus_req);

    // R8
    irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(wr_done && last && irq_en_q));

endmodule

// File: rtl/dma_xfer_channel.sv
module dma_xfer_channel #(
    parameter int AW    = 24,
    parameter int DW    = 16,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_load,
    input  logic [AW-1:0]    cfg_src,
    input  logic [AW-1:0]    cfg_dst,
    input  logic [CNT_W-1:0] cfg_count,
    input  logic [1:0]       cfg_src_mode,
    input  logic [1:0]       cfg_dst_mode,
    input  logic             cfg_word,
    input  logic             cfg_irq_en,
    input  logic             irq_clr,
    input  logic             xfer_req,
    output logic             bus_req,
    output logic             bus_we,
    output logic [AW-1:0]    bus_addr,
    output logic [DW-1:0]    bus_wdata,
    input  logic [DW-1:0]    bus_rdata,
    input  logic             bus_rdy,
    output logic             chan_en,
    output logic             irq
);
    localparam int BW = DW / 2;

    logic          load_ok, rd_latch, wr_done, last;
    logic          word_q;
    logic [1:0]    smode_q, dmode_q;
    logic [AW-1:0] src_cur, dst_cur, raw_addr;
    logic [DW-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q  <= 1'b0;
            smode_q <= '0;
            dmode_q <= '0;
        end else if (load_ok) begin
            word_q  <= cfg_word;
            smode_q <= cfg_src_mode;
            dmode_q <= cfg_dst_mode;
        end
    end

    dma_chan_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .cfg_load   (cfg_load),
        .cfg_irq_en (cfg_irq_en),
        .irq_clr    (irq_clr),
        .xfer_req   (xfer_req),
        .bus_rdy    (bus_rdy),
        .last       (last),
        .load_ok    (load_ok),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .rd_latch   (rd_latch),
        .wr_done    (wr_done),
        .chan_en    (chan_en),
        .irq        (irq)
    );

    dma_addr_unit #(.AW(AW)) u_src (
        .clk      (clk),
        .rst      (rst),
        .load     (load_ok),
        .load_val (cfg_src),
        .mode     (smode_q),
        .word     (word_q),
        .step     (wr_done),
        .cur      (src_cur)
    );

    dma_addr_unit #(.AW(AW)) u_dst (
        .clk      (clk),
        .rst      (rst),
        .load     (load_ok),
        .load_val (cfg_dst),
        .mode     (dmode_q),
        .word     (word_q),
        .step     (wr_done),
        .cur      (dst_cur)
    );

    dma_xfer_counter #(.CW(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (load_ok),
        .load_val (cfg_count),
        .dec      (wr_done),
        .last     (last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
        end else if (rd_latch) begin
            data_q <= word_q ? bus_rdata : {{(DW-BW){1'b0}}, bus_rdata[BW-1:0]};
        end
    end

    always_comb begin
        raw_addr  = bus_we ? dst_cur : src_cur;
        bus_addr  = {raw_addr[AW-1:1], raw_addr[0] & ~word_q};
        bus_wdata = data_q;
    end

    // R5
    word_even_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && word_q) |-> (bus_addr[0] == 1'b0));

    // R10
    wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_rdy) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

endmodule

// File: tb/test_dma_xfer_channel.sv
module test_dma_xfer_channel;
    localparam int AW = 24;
    localparam int DW = 16;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_load = 1'b0;
    logic [AW-1:0] cfg_src = '0, cfg_dst = '0;
    logic [CW-1:0] cfg_count = '0;
    logic [1:0]    cfg_src_mode = '0, cfg_dst_mode = '0;
    logic          cfg_word = 1'b0, cfg_irq_en = 1'b0, irq_clr = 1'b0, xfer_req = 1'b0;
    logic          bus_req, bus_we, chan_en, irq;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata = '0;
    logic          bus_rdy = 1'b0;

    int n_chk = 0, n_fail = 0;
    int waits = 0, wcnt = 0, nacc = 0, nwr = 0;
    logic pend = 1'b0;
    logic [AW-1:0] exp_src, exp_dst;
    logic [1:0]    cur_sm, cur_dm;
    logic          cur_word;
    logic [DW-1:0] last_rd;

    always #4 clk = ~clk;

    dma_xfer_channel #(.AW(AW), .DW(DW), .CNT_W(CW)) i_dma_xfer_channel (
        .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_src(cfg_src), .cfg_dst(cfg_dst),
        .cfg_count(cfg_count), .cfg_src_mode(cfg_src_mode), .cfg_dst_mode(cfg_dst_mode),
        .cfg_word(cfg_word), .cfg_irq_en(cfg_irq_en), .irq_clr(irq_clr), .xfer_req(xfer_req),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rdy(bus_rdy), .chan_en(chan_en), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] even(input logic [AW-1:0] a, input logic w);
        return w ? {a[AW-1:1], 1'b0} : a;
    endfunction

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] a, input logic [1:0] m, input logic w);
        logic [AW-1:0] s = w ? AW'(2) : AW'(1);
        if (m == 2'd1) return a + s;
        if (m == 2'd2) return a - s;
        return a;
    endfunction

    // bus model with wait states and per-access checking
    always @(negedge clk) begin
        if (!bus_req) begin
            bus_rdy = 1'b0;
            pend    = 1'b0;
        end else begin
            if (!pend || bus_rdy) begin
                pend = 1'b1;
                wcnt = waits;
            end
            if (wcnt == 0) begin
                bus_rdy = 1'b1;
                nacc++;
                if (!bus_we) begin
                    // R3 read from source, R5 even in word mode
                    check("R3/R5 read addr", 32'(bus_addr), 32'(even(exp_src, cur_word)));
                    last_rd   = {bus_addr[7:0] ^ 8'h5A, bus_addr[15:8] + 8'h33};
                    bus_rdata = last_rd;
                end else begin
                    nwr++;
                    // R3 write to destination, R4 address update
                    check("R4/R5 write addr", 32'(bus_addr), 32'(even(exp_dst, cur_word)));
                    check("R3 write data", 32'(bus_wdata),
                          32'(cur_word ? last_rd : {8'h00, last_rd[7:0]}));
                    exp_src = nxt(exp_src, cur_sm, cur_word);
                    exp_dst = nxt(exp_dst, cur_dm, cur_word);
                end
            end else begin
                bus_rdy = 1'b0;
                wcnt--;
            end
        end
    end

    task automatic do_xfer();
        int tgt = nwr + 1;
        xfer_req = 1'b1;
        @(negedge clk);
        xfer_req = 1'b0;
        wait (nwr == tgt);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic load_job(input logic [AW-1:0] s, d, input logic [CW-1:0] c,
                            input logic [1:0] sm, dm, input logic w, ien, input int wt);
        waits = wt; exp_src = s; exp_dst = d; cur_sm = sm; cur_dm = dm; cur_word = w;
        cfg_src = s; cfg_dst = d; cfg_count = c; cfg_src_mode = sm; cfg_dst_mode = dm;
        cfg_word = w; cfg_irq_en = ien; cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        check("R2 enable after load", 32'(chan_en), 32'd1);
        check("R2 irq after load", 32'(irq), 32'd0);
    endtask

    task automatic run_case(input logic [AW-1:0] s, d, input logic [CW-1:0] c,
                            input logic [1:0] sm, dm, input logic w, ien, input int wt);
        int n = (c == 0) ? (1 << CW) : int'(c);
        int a0;
        load_job(s, d, c, sm, dm, w, ien, wt);
        for (int i = 0; i < n; i++) begin
            if (chan_en !== 1'b1) check("R6 enabled before count done", 32'(chan_en), 32'd1);
            do_xfer();
        end
        // R6 / R7 channel stops after the loaded number of transfers
        check(c == 0 ? "R7 zero count stop" : "R6 count stop", 32'(chan_en), 32'd0);
        check("R8 irq on completion", 32'(irq), 32'(ien));
        // R9 request while disabled
        a0 = nacc;
        xfer_req = 1'b1;
        @(negedge clk);
        xfer_req = 1'b0;
        repeat (6) @(negedge clk);
        check("R9 no access when disabled", 32'(nacc), 32'(a0));
        check("R8 irq held", 32'(irq), 32'(ien));
        if (ien) begin
            irq_clr = 1'b1;
            @(negedge clk);
            irq_clr = 1'b0;
            check("R8 irq cleared", 32'(irq), 32'd0);
        end
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        int a0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 chan_en reset", 32'(chan_en), 32'd0);
        check("R1 irq reset", 32'(irq), 32'd0);
        check("R1 bus_req reset", 32'(bus_req), 32'd0);

        // R3 R4 R5 sweep over every mode pairing and both sizes
        for (int sm = 0; sm < 4; sm++)
            for (int dm = 0; dm < 4; dm++)
                for (int w = 0; w < 2; w++)
                    run_case(24'h000001 + AW'(sm), 24'hFFFFFF - AW'(dm), 8'd3,
                             2'(sm), 2'(dm), 1'(w), 1'(w ^ sm), (sm + dm + w) % 3);

        run_case(24'h123457, 24'h00ABCD, 8'd1, 2'd1, 2'd2, 1'b1, 1'b1, 0);
        // R7 zero count gives 2^CW transfers
        run_case(24'hFFFF00, 24'h000010, 8'd0, 2'd1, 2'd1, 1'b0, 1'b1, 0);

        // R9 request during a transfer in progress
        load_job(24'h000100, 24'h000200, 8'd2, 2'd1, 2'd1, 1'b1, 1'b0, 3);
        a0 = nacc;
        xfer_req = 1'b1;
        @(negedge clk);
        xfer_req = 1'b1;
        @(negedge clk);
        xfer_req = 1'b0;
        repeat (20) @(negedge clk);
        check("R9 busy request ignored", 32'(nacc), 32'(a0 + 2));
        check("R9 channel still armed", 32'(chan_en), 32'd1);
        do_xfer();
        check("R6 stop after second", 32'(chan_en), 32'd0);

        // R8 reload clears a pending irq
        load_job(24'h000300, 24'h000400, 8'd1, 2'd0, 2'd0, 1'b0, 1'b1, 1);
        do_xfer();
        check("R8 irq set", 32'(irq), 32'd1);
        load_job(24'h000300, 24'h000400, 8'd1, 2'd0, 2'd0, 1'b0, 1'b1, 1);
        check("R8 irq cleared by load", 32'(irq), 32'd0);

        // R1 reset in the middle of a transfer
        waits = 5;
        xfer_req = 1'b1;
        @(negedge clk);
        xfer_req = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 bus_req after mid reset", 32'(bus_req), 32'd0);
        check("R1 chan_en after mid reset", 32'(chan_en), 32'd0);
        check("R1 irq after mid reset", 32'(irq), 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule